// File: doc/BRIEF.md
# Hybrid Two-Array Translation Lookaside Buffer

This block stores address translations in two arrays that are searched together. The first is set-associative, `NWAYS` ways by `NSETS` sets, and every entry in it uses one page size that all of its entries share, given on `shared_ps`. The second is a small fully associative array, `FA_DEPTH` deep, in which each entry keeps its own page size. Every entry maps an aligned pair of neighbouring pages, an even page and an odd page, so the compared virtual bits start one bit above the page size.

The lookup port takes a virtual address under the current address-space identifier. One cycle later it returns a hit flag, a flat entry index and the two payload words of the entry. A command port drives the management operations. It can load the index register and its not-exist flag, search for the address on `cmd_va`, write the entry that the index register selects, or fill an entry chosen at random by a free-running LFSR. The flat index numbers the set-associative entries first as `way*NSETS + set`. The fully associative entries follow from `NWAYS*NSETS` upward.

Top module: `tlbx_hybrid`

## Requirements
- R1: After reset no entry exists, every lookup misses, and the index register and the not-exist flag both read 0.
- R2: A set-associative entry is found in set `(va >> (shared_ps+1)) mod NSETS`, and a hit reports flat index `way*NSETS + set` together with both payload words.
- R3: A non-global entry matches only when its stored ASID equals `cur_asid`. A global entry matches under any ASID.
- R4: An entry matches when the address bits at and above position PS+1 are equal, where PS is `shared_ps` for the set-associative array and the entry's own size for the fully associative array. Bits below PS+1 are ignored.
- R5: When several entries match, the set-associative array wins over the fully associative one. Within the set-associative array the lowest way wins, and within the fully associative array the lowest index wins.
- R6: Search (`cmd_op`=2) on a hit loads the matching index and clears the not-exist flag. On a miss it sets the flag and leaves the index unchanged.
- R7: Write (`cmd_op`=3) with the not-exist flag clear fills the entry at the index register with `cmd_va`, `cur_asid`, `cmd_glb` and both payload words. Only a fully associative target stores `cmd_ps`; a set-associative target keeps using `shared_ps`.
- R8: Write with the not-exist flag set removes the entry at the index register.
- R9: Fill (`cmd_op`=4) with `cmd_ps` equal to `shared_ps` writes a random way of the set taken from `cmd_va`. Any other page size writes a random fully associative slot.
- R10: A lookup request produces `lk_vld` in the next cycle only.
- R11: Load (`cmd_op`=1) copies `cmd_idx` and `cmd_ne` into the index register and the not-exist flag. No-op (`cmd_op`=0) changes neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_asid | input | ASID_W | Current address-space identifier |
| shared_ps | input | PS_W | Page size shared by the set-associative array |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_vld | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Flat index of the hit entry |
| lk_lo0 | output | DATA_W | Even-page payload |
| lk_lo1 | output | DATA_W | Odd-page payload |
| cmd_op | input | 3 | 0 no-op, 1 load index, 2 search, 3 write, 4 fill |
| cmd_idx | input | IDX_W | Index value for load |
| cmd_ne | input | 1 | Not-exist value for load |
| cmd_va | input | VA_W | Address for search, write and fill |
| cmd_ps | input | PS_W | Page size for write and fill |
| cmd_glb | input | 1 | Global flag for write and fill |
| cmd_lo0 | input | DATA_W | Even-page payload for write and fill |
| cmd_lo1 | input | DATA_W | Odd-page payload for write and fill |
| reg_idx | output | IDX_W | Index register |
| reg_ne | output | 1 | Not-exist flag |

## Verification
The bench builds the block with 4 ways, 8 sets, a 4-entry fully associative array and a 32-bit address, which gives flat indices 0 to 35 with the fully associative entries at 32 to 35. With arrays this small, a single set can hold a set-associative entry and a fully associative entry with the same address, and both fully associative entries and both ways can be made to collide, so each priority rule is checked. The 2 MiB pair size of the fully associative entries is set against the 8 KiB pairs of the shared size, which tests per-entry masking. Random fills are checked by the array and set they must land in, so the results do not depend on the LFSR sequence.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LDIDX = 3'd1,
        OP_SRCH  = 3'd2,
        OP_WR    = 3'd3,
        OP_FILL  = 3'd4
    } tlbx_op_e;

    localparam int PAIR_LSB = 13;
endpackage

// File: rtl/tlbx_cmp.sv
module tlbx_cmp #(
    parameter int VA_W   = 48,
    parameter int ASID_W = 10,
    parameter int PS_W   = 6
) (
    input  logic              ent_e,
    input  logic              ent_g,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic [VA_W-1:0]   ent_va,
    input  logic [PS_W-1:0]   ent_ps,
    input  logic [VA_W-1:0]   q_va,
    input  logic [ASID_W-1:0] q_asid,
    output logic              hit
);
    logic [VA_W-1:0] keep;
    logic [VA_W-1:0] all1;

    always_comb begin
        all1 = '1;
        keep = all1 << (int'(ent_ps) + 1);
        hit  = ent_e && (ent_g || (ent_asid == q_asid))
               && (((ent_va ^ q_va) & keep) == '0);
    end
endmodule

// File: rtl/tlbx_first.sv
module tlbx_first #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] pos
);
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                pos   = W'(i);
            end
        end
    end
endmodule

// File: rtl/tlbx_lfsr.sv
module tlbx_lfsr #(
    parameter int              LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] state
);
    logic [LFSR_W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q >> 1;
        if (state_q[0]) state_d = state_d ^ TAPS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LFSR_W'(1);
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/tlbx_hybrid.sv
module tlbx_hybrid
    import tlbx_pkg::*;
#(
    parameter int VA_W     = 48,
    parameter int ASID_W   = 10,
    parameter int PS_W     = 6,
    parameter int DATA_W   = 64,
    parameter int NWAYS    = 8,
    parameter int NSETS    = 256,
    parameter int FA_DEPTH = 64,
    parameter int LFSR_W   = 16,
    localparam int WAY_W   = $clog2(NWAYS),
    localparam int SET_W   = $clog2(NSETS),
    localparam int SA_W    = WAY_W + SET_W,
    localparam int NSA     = NWAYS * NSETS,
    localparam int FA_W    = $clog2(FA_DEPTH),
    localparam int NTOT    = NSA + FA_DEPTH,
    localparam int IDX_W   = $clog2(NTOT),
    localparam int VPN_W   = VA_W - PAIR_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [PS_W-1:0]   shared_ps,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_vld,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [DATA_W-1:0] lk_lo0,
    output logic [DATA_W-1:0] lk_lo1,
    input  logic [2:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic              cmd_ne,
    input  logic [VA_W-1:0]   cmd_va,
    input  logic [PS_W-1:0]   cmd_ps,
    input  logic              cmd_glb,
    input  logic [DATA_W-1:0] cmd_lo0,
    input  logic [DATA_W-1:0] cmd_lo1,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              reg_ne
);
    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic              ne;
        logic              vld;
        logic              hit;
        logic [IDX_W-1:0]  lidx;
        logic [DATA_W-1:0] lo0;
        logic [DATA_W-1:0] lo1;
    } regs_t;

    regs_t r_d, r_q;
    tlbx_op_e op;

    // set-associative storage
    logic [NSA-1:0]    sa_e;
    logic              sa_g    [NSA];
    logic [ASID_W-1:0] sa_asid [NSA];
    logic [VPN_W-1:0]  sa_vpn  [NSA];
    logic [DATA_W-1:0] sa_lo0  [NSA];
    logic [DATA_W-1:0] sa_lo1  [NSA];
    // fully associative storage
    logic [FA_DEPTH-1:0] fa_e;
    logic              fa_g    [FA_DEPTH];
    logic [ASID_W-1:0] fa_asid [FA_DEPTH];
    logic [VPN_W-1:0]  fa_vpn  [FA_DEPTH];
    logic [PS_W-1:0]   fa_ps   [FA_DEPTH];
    logic [DATA_W-1:0] fa_lo0  [FA_DEPTH];
    logic [DATA_W-1:0] fa_lo1  [FA_DEPTH];

    logic [LFSR_W-1:0] rnd;

    tlbx_lfsr #(.LFSR_W(LFSR_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (rnd)
    );

    // two query paths: 0 = lookup port, 1 = search command
    logic [VA_W-1:0]     q_va    [2];
    logic [SET_W-1:0]    q_set   [2];
    logic [NWAYS-1:0]    q_sahv  [2];
    logic [FA_DEPTH-1:0] q_fahv  [2];
    logic                q_safnd [2];
    logic [WAY_W-1:0]    q_saway [2];
    logic                q_fafnd [2];
    logic [FA_W-1:0]     q_fapos [2];

    assign q_va[0] = lk_va;
    assign q_va[1] = cmd_va;

    for (genvar q = 0; q < 2; q++) begin : g_query
        assign q_set[q] = SET_W'(q_va[q] >> (int'(shared_ps) + 1));

        for (genvar w = 0; w < NWAYS; w++) begin : g_way
            logic [SA_W-1:0] slot;
            assign slot = {WAY_W'(w), q_set[q]};
            tlbx_cmp #(.VA_W(VA_W), .ASID_W(ASID_W), .PS_W(PS_W)) u_cmp (
                .ent_e    (sa_e[slot]),
                .ent_g    (sa_g[slot]),
                .ent_asid (sa_asid[slot]),
                .ent_va   ({sa_vpn[slot], PAIR_LSB'(0)}),
                .ent_ps   (shared_ps),
                .q_va     (q_va[q]),
                .q_asid   (cur_asid),
                .hit      (q_sahv[q][w])
            );
        end

        for (genvar j = 0; j < FA_DEPTH; j++) begin : g_fa
            tlbx_cmp #(.VA_W(VA_W), .ASID_W(ASID_W), .PS_W(PS_W)) u_cmp (
                .ent_e    (fa_e[j]),
                .ent_g    (fa_g[j]),
                .ent_asid (fa_asid[j]),
                .ent_va   ({fa_vpn[j], PAIR_LSB'(0)}),
                .ent_ps   (fa_ps[j]),
                .q_va     (q_va[q]),
                .q_asid   (cur_asid),
                .hit      (q_fahv[q][j])
            );
        end

        tlbx_first #(.N(NWAYS), .W(WAY_W)) u_sa_first (
            .req   (q_sahv[q]),
            .found (q_safnd[q]),
            .pos   (q_saway[q])
        );
        tlbx_first #(.N(FA_DEPTH), .W(FA_W)) u_fa_first (
            .req   (q_fahv[q]),
            .found (q_fafnd[q]),
            .pos   (q_fapos[q])
        );
    end

    // write-side decode
    logic              sa_we, fa_we, wr_clr;
    logic [SA_W-1:0]   sa_wslot;
    logic [FA_W-1:0]   fa_wslot;
    logic [PS_W-1:0]   wr_ps;
    logic [SET_W-1:0]  fill_set;
    logic [SA_W-1:0]   lk_saslot;

    always_comb begin
        op       = tlbx_op_e'(cmd_op);
        r_d      = r_q;
        sa_we    = 1'b0;
        fa_we    = 1'b0;
        wr_clr   = 1'b0;
        sa_wslot = '0;
        fa_wslot = '0;
        wr_ps    = cmd_ps;
        fill_set = SET_W'(cmd_va >> (int'(shared_ps) + 1));

        // lookup result, registered
        lk_saslot = {q_saway[0], q_set[0]};
        r_d.vld   = lk_req;
        r_d.hit   = 1'b0;
        r_d.lidx  = '0;
        r_d.lo0   = '0;
        r_d.lo1   = '0;
        if (lk_req && q_safnd[0]) begin
            r_d.hit  = 1'b1;
            r_d.lidx = IDX_W'(lk_saslot);
            r_d.lo0  = sa_lo0[lk_saslot];
            r_d.lo1  = sa_lo1[lk_saslot];
        end else if (lk_req && q_fafnd[0]) begin
            r_d.hit  = 1'b1;
            r_d.lidx = IDX_W'(NSA) + IDX_W'(q_fapos[0]);
            r_d.lo0  = fa_lo0[q_fapos[0]];
            r_d.lo1  = fa_lo1[q_fapos[0]];
        end

        case (op)
            OP_LDIDX: begin
                r_d.idx = cmd_idx;
                r_d.ne  = cmd_ne;
            end
            OP_SRCH: begin
                if (q_safnd[1]) begin
                    r_d.idx = IDX_W'({q_saway[1], q_set[1]});
                    r_d.ne  = 1'b0;
                end else if (q_fafnd[1]) begin
                    r_d.idx = IDX_W'(NSA) + IDX_W'(q_fapos[1]);
                    r_d.ne  = 1'b0;
                end else begin
                    r_d.ne  = 1'b1;
                end
            end
            OP_WR: begin
                wr_clr = r_q.ne;
                if (32'(r_q.idx) < NSA) begin
                    sa_we    = 1'b1;
                    sa_wslot = SA_W'(r_q.idx);
                end else if (32'(r_q.idx) < NTOT) begin
                    fa_we    = 1'b1;
                    fa_wslot = FA_W'(r_q.idx - IDX_W'(NSA));
                end
            end
            OP_FILL: begin
                if (cmd_ps == shared_ps) begin
                    sa_we    = 1'b1;
                    sa_wslot = {WAY_W'(rnd % LFSR_W'(NWAYS)), fill_set};
                end else begin
                    fa_we    = 1'b1;
                    fa_wslot = FA_W'(rnd % LFSR_W'(FA_DEPTH));
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // exist bits carry reset; entry contents do not
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sa_e <= '0;
            fa_e <= '0;
        end else begin
            if (sa_we) sa_e[sa_wslot] <= !wr_clr;
            if (fa_we) fa_e[fa_wslot] <= !wr_clr;
        end
    end

    always_ff @(posedge clk) begin
        if (sa_we && !wr_clr) begin
            sa_g[sa_wslot]    <= cmd_glb;
            sa_asid[sa_wslot] <= cur_asid;
            sa_vpn[sa_wslot]  <= cmd_va[VA_W-1:PAIR_LSB];
            sa_lo0[sa_wslot]  <= cmd_lo0;
            sa_lo1[sa_wslot]  <= cmd_lo1;
        end
        if (fa_we && !wr_clr) begin
            fa_g[fa_wslot]    <= cmd_glb;
            fa_asid[fa_wslot] <= cur_asid;
            fa_vpn[fa_wslot]  <= cmd_va[VA_W-1:PAIR_LSB];
            fa_ps[fa_wslot]   <= wr_ps;
            fa_lo0[fa_wslot]  <= cmd_lo0;
            fa_lo1[fa_wslot]  <= cmd_lo1;
        end
    end

    assign lk_vld  = r_q.vld;
    assign lk_hit  = r_q.hit;
    assign lk_idx  = r_q.lidx;
    assign lk_lo0  = r_q.lo0;
    assign lk_lo1  = r_q.lo1;
    assign reg_idx = r_q.idx;
    assign reg_ne  = r_q.ne;
endmodule

// File: rtl/tlbx_hybrid_chk.sv
module tlbx_hybrid_chk #(
    parameter int IDX_W = 12,
    parameter int NTOT  = 2112
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cmd_op,
    input logic [IDX_W-1:0] cmd_idx,
    input logic             cmd_ne,
    input logic [IDX_W-1:0] reg_idx,
    input logic             reg_ne,
    input logic             lk_req,
    input logic             lk_vld,
    input logic             lk_hit,
    input logic [IDX_W-1:0] lk_idx
);
    p_vld_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_vld);

    p_vld_only_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_vld);

    p_hit_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_vld && (32'(lk_idx) < NTOT)));

    p_search_miss_keeps_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd2) |=> (!reg_ne || (reg_idx == $past(reg_idx))));

    p_load_idx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd1) |=> ((reg_idx == $past(cmd_idx)) && (reg_ne == $past(cmd_ne))));

    p_nop_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd0) |=> ($stable(reg_idx) && $stable(reg_ne)));
endmodule

bind tlbx_hybrid tlbx_hybrid_chk #(.IDX_W(IDX_W), .NTOT(NTOT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_op  (cmd_op),
    .cmd_idx (cmd_idx),
    .cmd_ne  (cmd_ne),
    .reg_idx (reg_idx),
    .reg_ne  (reg_ne),
    .lk_req  (lk_req),
    .lk_vld  (lk_vld),
    .lk_hit  (lk_hit),
    .lk_idx  (lk_idx)
);

// File: tb/sim_tlbx_hybrid.sv
module sim_tlbx_hybrid;
    localparam int VA_W = 32, ASID_W = 10, PS_W = 6, DATA_W = 16;
    localparam int NWAYS = 4, NSETS = 8, FA_DEPTH = 4, IDX_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ASID_W-1:0] cur_asid = 10'd3;
    logic [PS_W-1:0]   shared_ps = 6'd12;
    logic              lk_req = 1'b0;
    logic [VA_W-1:0]   lk_va = '0;
    logic              lk_vld, lk_hit;
    logic [IDX_W-1:0]  lk_idx;
    logic [DATA_W-1:0] lk_lo0, lk_lo1;
    logic [2:0]        cmd_op = 3'd0;
    logic [IDX_W-1:0]  cmd_idx = '0;
    logic              cmd_ne = 1'b0;
    logic [VA_W-1:0]   cmd_va = '0;
    logic [PS_W-1:0]   cmd_ps = 6'd12;
    logic              cmd_glb = 1'b0;
    logic [DATA_W-1:0] cmd_lo0 = '0, cmd_lo1 = '0;
    logic [IDX_W-1:0]  reg_idx;
    logic              reg_ne;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tlbx_hybrid #(.VA_W(VA_W), .ASID_W(ASID_W), .PS_W(PS_W), .DATA_W(DATA_W),
                  .NWAYS(NWAYS), .NSETS(NSETS), .FA_DEPTH(FA_DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .shared_ps(shared_ps),
        .lk_req(lk_req), .lk_va(lk_va), .lk_vld(lk_vld), .lk_hit(lk_hit),
        .lk_idx(lk_idx), .lk_lo0(lk_lo0), .lk_lo1(lk_lo1),
        .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_ne(cmd_ne), .cmd_va(cmd_va),
        .cmd_ps(cmd_ps), .cmd_glb(cmd_glb), .cmd_lo0(cmd_lo0), .cmd_lo1(cmd_lo1),
        .reg_idx(reg_idx), .reg_ne(reg_ne)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [VA_W-1:0] va,
                       input logic [PS_W-1:0] ps, input logic g,
                       input logic [DATA_W-1:0] l0, input logic [DATA_W-1:0] l1);
        @(negedge clk);
        cmd_op = op; cmd_va = va; cmd_ps = ps; cmd_glb = g; cmd_lo0 = l0; cmd_lo1 = l1;
        @(negedge clk);
        cmd_op = 3'd0;
    endtask

    task automatic ldidx(input int idx, input logic ne);
        @(negedge clk);
        cmd_op = 3'd1; cmd_idx = IDX_W'(idx); cmd_ne = ne;
        @(negedge clk);
        cmd_op = 3'd0;
    endtask

    task automatic look(input logic [VA_W-1:0] va);
        @(negedge clk);
        lk_req = 1'b1; lk_va = va;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 idx", reg_idx, 0);
        chk("R1 ne", reg_ne, 0);
        look(32'h0012_A000);
        chk("R1 miss", lk_hit, 0);
        chk("R10 vld", lk_vld, 1);
        @(negedge clk);
        chk("R10 vld drops", lk_vld, 0);
    endtask

    task automatic t_sa_write;
        ldidx(13, 1'b0);
        chk("R11 idx", reg_idx, 13);
        chk("R11 ne", reg_ne, 0);
        cmd(3'd3, 32'h0012_A000, 6'd20, 1'b0, 16'h1111, 16'h2222);
        chk("R11 nop keeps idx", reg_idx, 13);
        look(32'h0012_B7FC);
        chk("R2 hit", lk_hit, 1);
        chk("R2 idx", lk_idx, 13);
        chk("R7 lo0", lk_lo0, 16'h1111);
        chk("R7 lo1", lk_lo1, 16'h2222);
        look(32'h0012_C000);
        chk("R4 R7 shared size miss", lk_hit, 0);
    endtask

    task automatic t_asid;
        cur_asid = 10'd4;
        look(32'h0012_A000);
        chk("R3 asid miss", lk_hit, 0);
        ldidx(19, 1'b0);
        cmd(3'd3, 32'h0040_6000, 6'd12, 1'b1, 16'h3333, 16'h4444);
        cur_asid = 10'd7;
        look(32'h0040_7FFF);
        chk("R3 global hit", lk_hit, 1);
        chk("R3 global idx", lk_idx, 19);
        cur_asid = 10'd3;
        look(32'h0012_A000);
        chk("R3 own asid hit", lk_hit, 1);
    endtask

    task automatic t_fa_ps;
        ldidx(34, 1'b0);
        cmd(3'd3, 32'h0100_0000, 6'd20, 1'b0, 16'h5555, 16'h6666);
        look(32'h011F_FFFF);
        chk("R4 fa hit", lk_hit, 1);
        chk("R4 fa idx", lk_idx, 34);
        chk("R7 fa lo1", lk_lo1, 16'h6666);
        look(32'h0120_0000);
        chk("R4 fa miss", lk_hit, 0);
    endtask

    task automatic t_prio;
        ldidx(35, 1'b0);
        cmd(3'd3, 32'h0040_6000, 6'd12, 1'b1, 16'h7777, 16'h0);
        look(32'h0040_6000);
        chk("R5 sa over fa", lk_idx, 19);
        ldidx(3, 1'b0);
        cmd(3'd3, 32'h0040_6000, 6'd12, 1'b1, 16'h8888, 16'h0);
        look(32'h0040_6000);
        chk("R5 low way idx", lk_idx, 3);
        chk("R5 low way lo0", lk_lo0, 16'h8888);
        ldidx(32, 1'b0);
        cmd(3'd3, 32'h0108_0000, 6'd20, 1'b0, 16'h9999, 16'h0);
        look(32'h0100_0000);
        chk("R5 low fa idx", lk_idx, 32);
    endtask

    task automatic t_search;
        cmd(3'd2, 32'h0100_0010, 6'd12, 1'b0, 16'h0, 16'h0);
        chk("R6 hit ne", reg_ne, 0);
        chk("R6 hit idx", reg_idx, 32);
        cmd(3'd2, 32'h0800_0000, 6'd12, 1'b0, 16'h0, 16'h0);
        chk("R6 miss ne", reg_ne, 1);
        chk("R6 miss idx kept", reg_idx, 32);
    endtask

    task automatic t_clear;
        ldidx(32, 1'b1);
        cmd(3'd3, 32'h0, 6'd12, 1'b0, 16'h0, 16'h0);
        look(32'h0100_0000);
        chk("R8 fa cleared idx", lk_idx, 34);
        chk("R8 fa cleared lo0", lk_lo0, 16'h5555);
        ldidx(3, 1'b1);
        cmd(3'd3, 32'h0, 6'd12, 1'b0, 16'h0, 16'h0);
        look(32'h0040_6000);
        chk("R8 sa cleared", lk_idx, 19);
    endtask

    task automatic t_fill;
        cmd(3'd4, 32'h0055_E000, 6'd12, 1'b0, 16'hAAAA, 16'h0);
        cmd(3'd2, 32'h0055_E000, 6'd12, 1'b0, 16'h0, 16'h0);
        chk("R9 sa fill found", reg_ne, 0);
        chk("R9 sa fill array", (reg_idx < 32), 1);
        chk("R9 sa fill set", reg_idx % 8, 7);
        look(32'h0055_E000);
        chk("R9 sa fill data", lk_lo0, 16'hAAAA);
        cmd(3'd4, 32'h0300_0000, 6'd16, 1'b0, 16'hBBBB, 16'h0);
        cmd(3'd2, 32'h0301_FFFF, 6'd12, 1'b0, 16'h0, 16'h0);
        chk("R9 fa fill found", reg_ne, 0);
        chk("R9 fa fill array", (reg_idx >= 32), 1);
        look(32'h0300_0000);
        chk("R9 fa fill data", lk_lo0, 16'hBBBB);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_sa_write;
        t_asid;
        t_fa_ps;
        t_prio;
        t_search;
        t_clear;
        t_fill;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1..: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule